// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which of fifteen message objects takes a received CAN frame. A frame decoder presents the received identifier, the frame format (standard 11-bit or extended 29-bit), the remote-request bit and the two reserved bits, and pulses a frame-end strobe. Each object supplies its own identifier tag and mask, its own identifier format, compare bits for the remote-request and reserved fields, a receive-enable and a flag saying its buffer still holds unread data.

Every object is compared in parallel. A one in a mask bit means the tag bit must equal the received bit, and a zero means the bit is ignored. The remote-request bit and the frame format each have a separate compare-enable. When several objects accept the same frame, the lowest-numbered one wins. One clock after the strobe the block reports a hit flag, the binary index of the winner and, when the winner's buffer is still full, an overrun bit for that object.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, `hit_o` is 0, `hit_idx_o` is 0 and `ovr_o` is all zeros.
- R2: The results are registered: they reflect the inputs present at the clock edge where `frame_end_i` is 1 and appear after that edge; at an edge where `frame_end_i` is 0 the next `hit_o` is 0 and `ovr_o` is zero, whatever the other inputs are.
- R3: An identifier bit takes part in the comparison only where the object's mask bit is 1; a masked-off bit may differ from the tag without preventing acceptance.
- R4: An object whose format bit `obj_ext_i[k]` is 0 compares only received identifier bits [10:0]; bits [28:11] are ignored. With the format bit 1 it compares all bits [28:0].
- R5: When `rtr_msk_i[k]` is 1 the received remote-request bit must equal `rtr_tag_i[k]`; when 0 it is ignored.
- R6: When `ide_msk_i[k]` is 1 the received format `rx_ext_i` must equal `obj_ext_i[k]`; when 0 frames of either format may be accepted.
- R7: The received reserved bit 0 must always equal `rb0_tag_i[k]`; reserved bit 1 must equal `rb1_tag_i[k]` only in extended frames (`rx_ext_i` = 1) and is ignored in standard frames.
- R8: An object with `rx_en_i[k]` = 0 (disabled or set up for transmission) never accepts a frame.
- R9: When several objects accept, `hit_idx_o` is the lowest accepting object number, encoded in binary.
- R10: On a hit, `ovr_o` has exactly bit k set when the winner k has `buf_full_i[k]` = 1 and is otherwise zero; a full buffer on a non-winning object sets nothing, and the hit is still reported.
- R11: When no object accepts a strobed frame, `hit_o` is 0, `hit_idx_o` is 0 and `ovr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end_i | input | 1 | One-cycle strobe: received fields are valid |
| rx_id_i | input | 29 | Received identifier; standard frames use bits [10:0] |
| rx_ext_i | input | 1 | Received format, 1 = extended |
| rx_rtr_i | input | 1 | Received remote-request bit |
| rx_rb0_i | input | 1 | Received reserved bit 0 |
| rx_rb1_i | input | 1 | Received reserved bit 1 |
| tag_i | input | 15*29 | Identifier tags, object k in bits [k*29 +: 29] |
| msk_i | input | 15*29 | Identifier masks, same packing |
| obj_ext_i | input | 15 | Per-object identifier format, 1 = extended |
| rtr_tag_i | input | 15 | Per-object remote-request tag |
| rtr_msk_i | input | 15 | Per-object remote-request compare enable |
| ide_msk_i | input | 15 | Per-object format compare enable |
| rb0_tag_i | input | 15 | Per-object reserved bit 0 tag |
| rb1_tag_i | input | 15 | Per-object reserved bit 1 tag |
| rx_en_i | input | 15 | Per-object receive enable |
| buf_full_i | input | 15 | Per-object buffer holds unread data |
| hit_o | output | 1 | Some object accepted the last strobed frame |
| hit_idx_o | output | 4 | Binary number of the winning object |
| ovr_o | output | 15 | Overrun flag for the winning object |

## Verification
Directed frames first hold one object fixed and vary a single field at a time (an identifier bit inside and outside the mask, upper identifier bits against a standard-format object, the remote-request bit with its compare on and off, the format with its compare on and off, each reserved bit in both frame formats), so that each miss can be traced to one comparison term. Priority is tried with three objects accepting the same frame and then removing winners one at a time, which separates lowest-first from highest-first or any other order. Overrun is driven with the full flag on the winner and on a losing object, which tells a winner-only overrun from one raised on every matching object. A run of pseudo-random configurations and frames against an independent reference model covers combinations the directed cases leave out.

// File: rtl/can_flt_pkg.sv
`timescale 1ns/1ps
package can_flt_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  // Bits of the identifier that a given object format looks at.
  function automatic logic [ID_W-1:0] id_span(input logic ext);
    return ext ? {ID_W{1'b1}} : {{(ID_W-STD_W){1'b0}}, {STD_W{1'b1}}};
  endfunction

  // True when every compared bit agrees with the tag.
  function automatic logic id_agree(input logic [ID_W-1:0] rx,
                                    input logic [ID_W-1:0] tag,
                                    input logic [ID_W-1:0] msk,
                                    input logic            ext);
    return ((rx ^ tag) & msk & id_span(ext)) == '0;
  endfunction

  // An optional single-bit compare: off means always agrees.
  function automatic logic bit_agree(input logic rx, input logic tag, input logic use_it);
    return !use_it || (rx == tag);
  endfunction
endpackage

// File: rtl/can_obj_match.sv
`timescale 1ns/1ps
module can_obj_match
  import can_flt_pkg::*;
(
  input  logic [ID_W-1:0] rx_id_i,
  input  logic            rx_ext_i,
  input  logic            rx_rtr_i,
  input  logic            rx_rb0_i,
  input  logic            rx_rb1_i,
  input  logic [ID_W-1:0] tag_i,
  input  logic [ID_W-1:0] msk_i,
  input  logic            obj_ext_i,
  input  logic            rtr_tag_i,
  input  logic            rtr_msk_i,
  input  logic            ide_msk_i,
  input  logic            rb0_tag_i,
  input  logic            rb1_tag_i,
  input  logic            en_i,
  output logic            match_o
);
  logic id_ok, rtr_ok, fmt_ok, rb0_ok, rb1_ok;

  assign id_ok   = id_agree(rx_id_i, tag_i, msk_i, obj_ext_i);
  assign rtr_ok  = bit_agree(rx_rtr_i, rtr_tag_i, rtr_msk_i);
  assign fmt_ok  = bit_agree(rx_ext_i, obj_ext_i, ide_msk_i);
  assign rb0_ok  = bit_agree(rx_rb0_i, rb0_tag_i, 1'b1);
  // Reserved bit 1 only exists in extended frames.
  assign rb1_ok  = bit_agree(rx_rb1_i, rb1_tag_i, rx_ext_i);
  assign match_o = en_i & id_ok & rtr_ok & fmt_ok & rb0_ok & rb1_ok;
endmodule

// File: rtl/can_prio_pick.sv
`timescale 1ns/1ps
module can_prio_pick #(
  parameter int N  = 15,
  parameter int IW = 4
) (
  input  logic [N-1:0]  cand_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // Scan downward so the lowest set bit is written last and wins.
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (cand_i[k]) idx_o = IW'(k);
    end
  end
  assign any_o = |cand_i;
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter
  import can_flt_pkg::*;
#(
  parameter int NUM_OBJ = 15
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_end_i,
  input  logic [ID_W-1:0]           rx_id_i,
  input  logic                      rx_ext_i,
  input  logic                      rx_rtr_i,
  input  logic                      rx_rb0_i,
  input  logic                      rx_rb1_i,
  input  logic [NUM_OBJ*ID_W-1:0]   tag_i,
  input  logic [NUM_OBJ*ID_W-1:0]   msk_i,
  input  logic [NUM_OBJ-1:0]        obj_ext_i,
  input  logic [NUM_OBJ-1:0]        rtr_tag_i,
  input  logic [NUM_OBJ-1:0]        rtr_msk_i,
  input  logic [NUM_OBJ-1:0]        ide_msk_i,
  input  logic [NUM_OBJ-1:0]        rb0_tag_i,
  input  logic [NUM_OBJ-1:0]        rb1_tag_i,
  input  logic [NUM_OBJ-1:0]        rx_en_i,
  input  logic [NUM_OBJ-1:0]        buf_full_i,
  output logic                      hit_o,
  output logic [$clog2(NUM_OBJ)-1:0] hit_idx_o,
  output logic [NUM_OBJ-1:0]        ovr_o
);
  localparam int IDX_W = $clog2(NUM_OBJ);

  // Named internal events for the assertions.
  logic [NUM_OBJ-1:0] cand_vec;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;
  logic               accept;
  logic [NUM_OBJ-1:0] win_onehot;

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
    can_obj_match u_match (
      .rx_id_i   (rx_id_i),
      .rx_ext_i  (rx_ext_i),
      .rx_rtr_i  (rx_rtr_i),
      .rx_rb0_i  (rx_rb0_i),
      .rx_rb1_i  (rx_rb1_i),
      .tag_i     (tag_i[g*ID_W +: ID_W]),
      .msk_i     (msk_i[g*ID_W +: ID_W]),
      .obj_ext_i (obj_ext_i[g]),
      .rtr_tag_i (rtr_tag_i[g]),
      .rtr_msk_i (rtr_msk_i[g]),
      .ide_msk_i (ide_msk_i[g]),
      .rb0_tag_i (rb0_tag_i[g]),
      .rb1_tag_i (rb1_tag_i[g]),
      .en_i      (rx_en_i[g]),
      .match_o   (cand_vec[g])
    );
  end

  can_prio_pick #(.N(NUM_OBJ), .IW(IDX_W)) u_pick (
    .cand_i (cand_vec),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  assign accept     = frame_end_i & pick_any;
  assign win_onehot = NUM_OBJ'(1) << pick_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
      ovr_o     <= '0;
    end else begin
      hit_o     <= accept;
      hit_idx_o <= accept ? pick_idx : '0;
      ovr_o     <= accept ? (buf_full_i & win_onehot) : '0;
    end
  end

  // Picker result must be an accepting object (R9).
  p_pick_is_cand_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> ((cand_vec >> pick_idx) & NUM_OBJ'(1)) != '0);

  // No accepting object below the chosen one (R9).
  p_pick_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> (cand_vec & (win_onehot - NUM_OBJ'(1))) == '0);

  // A hit only follows a strobe (R2).
  p_hit_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(frame_end_i));

  // Without a strobe the next outputs are quiet (R2).
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end_i |=> (!hit_o && ovr_o == '0));

  // Overrun names only the winner and comes with a hit (R10).
  p_ovr_winner_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_o != '0) |-> (hit_o && ovr_o == (NUM_OBJ'(1) << hit_idx_o)));

  // At most one overrun bit at a time (R10).
  p_ovr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ovr_o));

  // A miss leaves the index at zero (R11).
  p_miss_idx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> hit_idx_o == '0);
endmodule

// File: tb/tb_can_accept_filter.sv
`timescale 1ns/1ps
module tb_can_accept_filter;
  localparam int N  = 15;
  localparam int IW = 29;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          frame_end = 1'b0;
  logic [IW-1:0] rx_id = '0;
  logic          rx_ext = 1'b0, rx_rtr = 1'b0, rx_rb0 = 1'b0, rx_rb1 = 1'b0;
  logic [IW-1:0] tag [N];
  logic [IW-1:0] msk [N];
  logic [N-1:0]  o_ext, rtr_tag, rtr_msk, ide_msk, rb0_tag, rb1_tag, en, full;
  logic [N*IW-1:0] tag_flat, msk_flat;

  logic          hit;
  logic [3:0]    hidx;
  logic [N-1:0]  ovr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always_comb begin
    for (int k = 0; k < N; k++) begin
      tag_flat[k*IW +: IW] = tag[k];
      msk_flat[k*IW +: IW] = msk[k];
    end
  end

  can_accept_filter dut (
    .clk(clk), .rst_n(rst_n), .frame_end_i(frame_end),
    .rx_id_i(rx_id), .rx_ext_i(rx_ext), .rx_rtr_i(rx_rtr),
    .rx_rb0_i(rx_rb0), .rx_rb1_i(rx_rb1),
    .tag_i(tag_flat), .msk_i(msk_flat), .obj_ext_i(o_ext),
    .rtr_tag_i(rtr_tag), .rtr_msk_i(rtr_msk), .ide_msk_i(ide_msk),
    .rb0_tag_i(rb0_tag), .rb1_tag_i(rb1_tag), .rx_en_i(en),
    .buf_full_i(full), .hit_o(hit), .hit_idx_o(hidx), .ovr_o(ovr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_cfg();
    for (int k = 0; k < N; k++) begin
      tag[k] = '0;
      msk[k] = '1;
    end
    o_ext = '0; rtr_tag = '0; rtr_msk = '0; ide_msk = '0;
    rb0_tag = '0; rb1_tag = '0; en = '0; full = '0;
  endtask

  task automatic set_rx(input logic [IW-1:0] id, input logic ext,
                        input logic rtr, input logic b0, input logic b1);
    rx_id = id; rx_ext = ext; rx_rtr = rtr; rx_rb0 = b0; rx_rb1 = b1;
  endtask

  // Strobe one frame and compare against a hand-derived expectation.
  task automatic frame_expect(input string req, input logic eh,
                              input int ei, input logic [N-1:0] eo);
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
    chk(req, "hit", 32'(hit), 32'(eh));
    chk(req, "idx", 32'(hidx), 32'(ei));
    chk(req, "ovr", 32'(ovr), 32'(eo));
  endtask

  // Independent reference for one object.
  function automatic logic model_ok(input int k);
    if (!en[k]) return 1'b0;
    for (int b = 0; b < IW; b++)
      if ((b < 11 || o_ext[k]) && msk[k][b] && (rx_id[b] !== tag[k][b])) return 1'b0;
    if (rtr_msk[k] && (rx_rtr !== rtr_tag[k])) return 1'b0;
    if (ide_msk[k] && (rx_ext !== o_ext[k])) return 1'b0;
    if (rx_rb0 !== rb0_tag[k]) return 1'b0;
    if (rx_ext && (rx_rb1 !== rb1_tag[k])) return 1'b0;
    return 1'b1;
  endfunction

  task automatic frame_model(input string req);
    logic eh; int ei; logic [N-1:0] eo;
    eh = 1'b0; ei = 0; eo = '0;
    for (int k = 0; k < N; k++) begin
      if (!eh && model_ok(k)) begin
        eh = 1'b1; ei = k;
        if (full[k]) eo[k] = 1'b1;
      end
    end
    frame_expect(req, eh, ei, eo);
  endtask

  task automatic t_reset();
    chk("R1", "hit in reset", 32'(hit), 0);
    chk("R1", "idx in reset", 32'(hidx), 0);
    chk("R1", "ovr in reset", 32'(ovr), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "hit after reset", 32'(hit), 0);
  endtask

  task automatic t_mask();
    clear_cfg();
    en[3] = 1'b1; tag[3] = 29'h123; msk[3] = 29'h7FF;
    set_rx(29'h123, 0, 0, 0, 0); frame_expect("R3", 1, 3, '0);
    set_rx(29'h124, 0, 0, 0, 0); frame_expect("R11", 0, 0, '0);
    msk[3] = 29'h7F0;
    set_rx(29'h12F, 0, 0, 0, 0); frame_expect("R3", 1, 3, '0);
    set_rx(29'h133, 0, 0, 0, 0); frame_expect("R3", 0, 0, '0);
  endtask

  task automatic t_format();
    clear_cfg();
    en[3] = 1'b1; tag[3] = 29'h123;
    set_rx(29'h1FFFF123, 1, 0, 0, 0); frame_expect("R4", 1, 3, '0);
    o_ext[3] = 1'b1; tag[3] = 29'h0ABC1123;
    set_rx(29'h0ABD1123, 1, 0, 0, 0); frame_expect("R4", 0, 0, '0);
    set_rx(29'h0ABC1123, 1, 0, 0, 0); frame_expect("R4", 1, 3, '0);
  endtask

  task automatic t_rtr();
    clear_cfg();
    en[1] = 1'b1; tag[1] = 29'h055; rtr_msk[1] = 1'b1;
    set_rx(29'h055, 0, 1, 0, 0); frame_expect("R5", 0, 0, '0);
    rtr_tag[1] = 1'b1; frame_expect("R5", 1, 1, '0);
    rtr_tag[1] = 1'b0; rtr_msk[1] = 1'b0; frame_expect("R5", 1, 1, '0);
  endtask

  task automatic t_ide();
    clear_cfg();
    en[1] = 1'b1; tag[1] = 29'h055; ide_msk[1] = 1'b1;
    set_rx(29'h00000055, 1, 0, 0, 0); frame_expect("R6", 0, 0, '0);
    set_rx(29'h055, 0, 0, 0, 0); frame_expect("R6", 1, 1, '0);
    ide_msk[1] = 1'b0;
    set_rx(29'h00000055, 1, 0, 0, 0); frame_expect("R6", 1, 1, '0);
  endtask

  task automatic t_rb();
    clear_cfg();
    en[1] = 1'b1; tag[1] = 29'h055; rb0_tag[1] = 1'b1;
    set_rx(29'h055, 0, 0, 0, 0); frame_expect("R7", 0, 0, '0);
    set_rx(29'h055, 0, 0, 1, 0); frame_expect("R7", 1, 1, '0);
    set_rx(29'h055, 0, 0, 1, 1); frame_expect("R7", 1, 1, '0);
    o_ext[1] = 1'b1;
    set_rx(29'h055, 1, 0, 1, 1); frame_expect("R7", 0, 0, '0);
    rb1_tag[1] = 1'b1; frame_expect("R7", 1, 1, '0);
  endtask

  task automatic t_disable();
    clear_cfg();
    tag[1] = 29'h055;
    set_rx(29'h055, 0, 0, 0, 0); frame_expect("R8", 0, 0, '0);
    en[1] = 1'b1; frame_expect("R8", 1, 1, '0);
  endtask

  task automatic t_prio();
    clear_cfg();
    for (int k = 0; k < N; k++) tag[k] = 29'h3A5;
    en[2] = 1'b1; en[7] = 1'b1; en[14] = 1'b1;
    set_rx(29'h3A5, 0, 0, 0, 0); frame_expect("R9", 1, 2, '0);
    en[2] = 1'b0; frame_expect("R9", 1, 7, '0);
    en[7] = 1'b0; frame_expect("R9", 1, 14, '0);
  endtask

  task automatic t_ovr();
    clear_cfg();
    for (int k = 0; k < N; k++) tag[k] = 29'h3A5;
    en[7] = 1'b1; en[14] = 1'b1; full[14] = 1'b1;
    set_rx(29'h3A5, 0, 0, 0, 0); frame_expect("R10", 1, 7, '0);
    full[7] = 1'b1; frame_expect("R10", 1, 7, 15'h0080);
    en[7] = 1'b0; frame_expect("R10", 1, 14, 15'h4000);
  endtask

  task automatic t_quiet();
    clear_cfg();
    en[0] = 1'b1; full[0] = 1'b1;
    set_rx(29'h000, 0, 0, 0, 0); frame_expect("R2", 1, 0, 15'h0001);
    @(negedge clk);
    chk("R2", "hit without strobe", 32'(hit), 0);
    chk("R2", "ovr without strobe", 32'(ovr), 0);
    en[4] = 1'b1;
    @(negedge clk);
    chk("R2", "hit stays low", 32'(hit), 0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 80; n++) begin
      for (int k = 0; k < N; k++) begin
        tag[k] = IW'($urandom);
        msk[k] = IW'($urandom & $urandom & $urandom);
      end
      o_ext = N'($urandom); rtr_tag = N'($urandom); rtr_msk = N'($urandom);
      ide_msk = N'($urandom); rb0_tag = N'($urandom); rb1_tag = N'($urandom);
      en = N'($urandom); full = N'($urandom);
      set_rx(IW'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      frame_model("R3");
    end
  endtask

  initial begin
    clear_cfg();
    @(negedge clk);
    t_reset();
    t_mask();
    t_format();
    t_rtr();
    t_ide();
    t_rb();
    t_disable();
    t_prio();
    t_ovr();
    t_quiet();
    t_random();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule